// File: doc/BRIEF.md
# Stereo Mono-Mix and Soft-Mute Stage

This stage takes the stereo sample stream that has already been volume-scaled and reshapes it before it reaches the two DAC modulators. Each accepted left/right pair can be halved by a fixed 6 dB attenuation. It can then be folded into a digital mono average that is steered to the left DAC, the right DAC or both. Finally it passes through a soft-mute gain that ramps toward zero or toward unity, one step per sample.

Samples enter and leave on valid/ready streams. An input pair is accepted on a rising clock edge when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty, or its content is being taken in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the output pair is held unchanged and no input is taken. The configuration pins are plain levels that are sampled with each accepted pair. The DAC enable flags follow the mix select directly.

After reset the stage is muted with zero gain. Playback needs `cfg_mute` to be cleared, and the sound then fades in over 256 samples.

Top module: `dmx_stage`

## Requirements
- R1: With mix select 00 (stereo) and unity gain, out_left and out_right equal the accepted in_left and in_right.
- R2: Mix select 01 puts floor((L+R)/2) on out_left and 0 on out_right.
- R3: Mix select 10 puts floor((L+R)/2) on out_right and 0 on out_left.
- R4: Mix select 11 puts floor((L+R)/2) on both outputs.
- R5: With cfg_atten high, each input is first shifted right arithmetically by one bit (floor of half), before any mixing.
- R6: The L+R sum is formed one bit wider than a sample, so two full-scale inputs of the same sign average to that same full-scale value without wrapping.
- R7: After reset, out_valid is low, in_ready is high and the soft-mute gain is 0, so samples accepted while muted come out as 0.
- R8: The output is floor(x*g/256), where x is the routed sample and g is the current gain. g is taken at acceptance and then steps by +1 per accepted pair while cfg_mute is low, saturating at 256 (exact pass-through).
- R9: While cfg_mute is high, g steps by -1 per accepted pair down to 0 and stays there.
- R10: The gain changes only on accepted pairs, never during idle or stalled cycles.
- R11: in_ready = !out_valid || out_ready, and the output pair stays stable while out_valid is high and out_ready is low.
- R12: dac_en_left is low only for mix select 10, and dac_en_right is low only for mix select 01. Otherwise both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_atten | input | 1 | Halve both inputs (-6 dB) |
| cfg_mix | input | 2 | Mono-mix routing select |
| cfg_mute | input | 1 | Ramp gain toward 0 when high, toward unity when low |
| in_valid | input | 1 | Input pair valid |
| in_ready | output | 1 | Stage can accept a pair |
| in_left | input | 24 | Signed left sample |
| in_right | input | 24 | Signed right sample |
| out_valid | output | 1 | Output pair valid |
| out_ready | input | 1 | Downstream takes the output pair |
| out_left | output | 24 | Signed sample to left DAC |
| out_right | output | 24 | Signed sample to right DAC |
| dac_en_left | output | 1 | Left DAC in use |
| dac_en_right | output | 1 | Right DAC in use |

## Verification
The bench goes after the negative-odd rounding of the halving and the averaging. A design that rounds toward zero there would be one LSB high on inputs such as -3. It also checks same-sign full-scale pairs in mono mode, where a sum kept at sample width would wrap to the opposite sign.

The fade is followed sample by sample, in both directions, up to and including saturation. An off-by-one in when the gain is applied, or a ramp that overshoots 256 or undershoots 0, shows as a wrong output value. A stall with mute active checks that the gain does not creep during held cycles, that the output stays frozen, and that the waiting input is not dropped.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
  typedef enum logic [1:0] {
    MIX_STEREO   = 2'b00,
    MIX_TO_LEFT  = 2'b01,
    MIX_TO_RIGHT = 2'b10,
    MIX_TO_BOTH  = 2'b11
  } mix_sel_e;
endpackage

// File: rtl/dmx_route.sv
module dmx_route
  import dmx_pkg::*;
#(
  parameter int W = 24
) (
  input  logic signed [W-1:0] l_in,
  input  logic signed [W-1:0] r_in,
  input  logic                atten,
  input  logic [1:0]          mix,
  output logic signed [W-1:0] l_out,
  output logic signed [W-1:0] r_out,
  output logic                en_l,
  output logic                en_r
);
  logic signed [W-1:0] l_a, r_a, avg;
  logic signed [W:0]   sum;

  // R5: -6 dB as a one-bit arithmetic shift
  assign l_a = atten ? (l_in >>> 1) : l_in;
  assign r_a = atten ? (r_in >>> 1) : r_in;

  // R6: one extra bit keeps the sum from wrapping
  assign sum = {l_a[W-1], l_a} + {r_a[W-1], r_a};
  assign avg = W'(sum >>> 1);

  always_comb begin
    l_out = l_a;
    r_out = r_a;
    en_l  = 1'b1;
    en_r  = 1'b1;
    case (mix_sel_e'(mix))
      MIX_STEREO:   ;
      MIX_TO_LEFT:  begin l_out = avg;     r_out = '0;  en_r = 1'b0; end
      MIX_TO_RIGHT: begin l_out = '0;      r_out = avg; en_l = 1'b0; end
      default:      begin l_out = avg;     r_out = avg;              end
    endcase
  end
endmodule

// File: rtl/dmx_ramp.sv
module dmx_ramp #(
  parameter int GB = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        step,
  input  logic        mute,
  output logic [GB:0] gain
);
  localparam logic [GB:0] UNITY = (GB+1)'(1) << GB;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gain <= '0;
    end else if (step) begin
      if (mute && gain != '0)
        gain <= gain - 1'b1;
      else if (!mute && gain != UNITY)
        gain <= gain + 1'b1;
    end
  end

  // R10: no movement without an accepted pair
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(gain));
  // R9: muting steps down by one
  a_r9_mute_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && mute && gain != '0) |=> gain == $past(gain) - 1'b1);
  // R8: gain never exceeds unity
  a_r8_gain_cap: assert property (@(posedge clk) disable iff (!rst_n)
    gain <= UNITY);
endmodule

// File: rtl/dmx_scale.sv
module dmx_scale #(
  parameter int W  = 24,
  parameter int GB = 8
) (
  input  logic signed [W-1:0] x,
  input  logic [GB:0]         gain,
  output logic signed [W-1:0] y
);
  logic signed [W+GB+1:0] prod;
  assign prod = x * $signed({1'b0, gain});
  assign y    = W'(prod >>> GB);
endmodule

// File: rtl/dmx_stage.sv
module dmx_stage
  import dmx_pkg::*;
#(
  parameter int W  = 24,
  parameter int GB = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_atten,
  input  logic [1:0]          cfg_mix,
  input  logic                cfg_mute,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic signed [W-1:0] in_left,
  input  logic signed [W-1:0] in_right,
  output logic                out_valid,
  input  logic                out_ready,
  output logic signed [W-1:0] out_left,
  output logic signed [W-1:0] out_right,
  output logic                dac_en_left,
  output logic                dac_en_right
);
  localparam int NCH = 2;

  logic                accept;
  logic [GB:0]         gain;
  logic signed [W-1:0] routed [NCH];
  logic signed [W-1:0] scaled [NCH];

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  dmx_route #(.W(W)) u_route (
    .l_in(in_left), .r_in(in_right), .atten(cfg_atten), .mix(cfg_mix),
    .l_out(routed[0]), .r_out(routed[1]),
    .en_l(dac_en_left), .en_r(dac_en_right)
  );

  dmx_ramp #(.GB(GB)) u_ramp (
    .clk(clk), .rst_n(rst_n), .step(accept), .mute(cfg_mute), .gain(gain)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    dmx_scale #(.W(W), .GB(GB)) u_scale (
      .x(routed[ch]), .gain(gain), .y(scaled[ch])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_left  <= scaled[0];
      out_right <= scaled[1];
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R11: held output while stalled
  a_r11_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_left) && $stable(out_right));
  // R2: left-only mono leaves the right DAC at zero
  a_r2_right_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cfg_mix == MIX_TO_LEFT) |=> out_right == '0);
  // R3: right-only mono leaves the left DAC at zero
  a_r3_left_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cfg_mix == MIX_TO_RIGHT) |=> out_left == '0);
  // R12: at least one DAC is always in use
  a_r12_one_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    dac_en_left || dac_en_right);
endmodule

// File: tb/tb_dmx_stage.sv
module tb_dmx_stage;
  logic clk = 0;
  logic rst_n = 0;
  logic cfg_atten = 0;
  logic [1:0] cfg_mix = 2'b00;
  logic cfg_mute = 1;
  logic in_valid = 0;
  logic in_ready;
  logic signed [23:0] in_left = 0, in_right = 0;
  logic out_valid;
  logic out_ready = 1;
  logic signed [23:0] out_left, out_right;
  logic dac_en_left, dac_en_right;

  int n_chk = 0, n_fail = 0;
  int g = 0;

  always #2 clk = ~clk;

  dmx_stage dut (
    .clk(clk), .rst_n(rst_n), .cfg_atten(cfg_atten), .cfg_mix(cfg_mix),
    .cfg_mute(cfg_mute), .in_valid(in_valid), .in_ready(in_ready),
    .in_left(in_left), .in_right(in_right), .out_valid(out_valid),
    .out_ready(out_ready), .out_left(out_left), .out_right(out_right),
    .dac_en_left(dac_en_left), .dac_en_right(dac_en_right)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint scl(input longint x, input int gg);
    return (x * gg) >>> 8;
  endfunction

  task automatic model(input longint l, input longint r, output longint el, output longint er);
    longint a, b, av;
    a = cfg_atten ? (l >>> 1) : l;
    b = cfg_atten ? (r >>> 1) : r;
    av = (a + b) >>> 1;
    case (cfg_mix)
      2'b00: begin el = a;  er = b;  end
      2'b01: begin el = av; er = 0;  end
      2'b10: begin el = 0;  er = av; end
      default: begin el = av; er = av; end
    endcase
    el = scl(el, g);
    er = scl(er, g);
  endtask

  task automatic step_gain();
    if (cfg_mute) begin if (g > 0) g--; end
    else begin if (g < 256) g++; end
  endtask

  task automatic push(input longint l, input longint r, input string req);
    longint el, er;
    model(l, r, el, er);
    @(negedge clk);
    in_left = 24'(l); in_right = 24'(r); in_valid = 1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    step_gain();
    chk({req, " left"}, longint'(out_left), el);
    chk({req, " right"}, longint'(out_right), er);
  endtask

  task automatic t_reset();
    chk("R7 out_valid", out_valid, 0);
    chk("R7 in_ready", in_ready, 1);
    chk("R12 en_left stereo", dac_en_left, 1);
    chk("R12 en_right stereo", dac_en_right, 1);
    push(1000, -2000, "R7 muted sample");
    chk("R7 zero left", longint'(out_left), 0);
  endtask

  task automatic t_unmute();
    cfg_mute = 0;
    for (int i = 0; i < 262; i++) push(24'sh100000, -24'sd777, "R8 fade in");
    chk("R8 unity reached", g, 256);
    chk("R8 unity left", longint'(out_left), 24'sh100000);
  endtask

  task automatic t_stereo();
    cfg_mix = 2'b00;
    push(123456, -654321, "R1 pattern a");
    push(-8388608, 8388607, "R1 pattern b");
    push(-1, 1, "R1 pattern c");
  endtask

  task automatic t_mono();
    cfg_mix = 2'b01;
    #1 chk("R12 en_right low", dac_en_right, 0);
    chk("R12 en_left high", dac_en_left, 1);
    push(1000, 3001, "R2 mono left");
    push(-3, 0, "R2 negative floor");
    cfg_mix = 2'b10;
    #1 chk("R12 en_left low", dac_en_left, 0);
    chk("R12 en_right high", dac_en_right, 1);
    push(500, -101, "R3 mono right");
    cfg_mix = 2'b11;
    #1 chk("R12 both on", dac_en_left + dac_en_right, 2);
    push(7, 8, "R4 mono both");
    push(-7, -8, "R4 negative");
  endtask

  task automatic t_atten();
    cfg_atten = 1;
    cfg_mix = 2'b00;
    push(-3, 5, "R5 stereo halve");
    push(-8388608, 8388607, "R5 extremes");
    cfg_mix = 2'b11;
    push(-5, -6, "R5 halve then mix");
    cfg_atten = 0;
  endtask

  task automatic t_overflow();
    cfg_mix = 2'b11;
    push(8388607, 8388607, "R6 max pair");
    chk("R6 max kept", longint'(out_left), 8388607);
    push(-8388608, -8388608, "R6 min pair");
    chk("R6 min kept", longint'(out_right), -8388608);
    cfg_mix = 2'b01;
    push(8388607, 8388606, "R6 near max");
  endtask

  task automatic t_stall();
    longint el, er;
    cfg_mix = 2'b00;
    cfg_mute = 1;
    @(negedge clk); out_ready = 1;
    @(negedge clk); out_ready = 0;
    push(4000, -4000, "R11 first pair");
    model(2000, 3000, el, er);
    in_left = 2000; in_right = 3000; in_valid = 1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R11 ready low", in_ready, 0);
      chk("R11 held", longint'(out_left), scl(4000, g + 1));
    end
    out_ready = 1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    step_gain();
    chk("R10 gain frozen in stall", longint'(out_left), el);
    chk("R10 gain frozen right", longint'(out_right), er);
  endtask

  task automatic t_mute();
    cfg_mute = 1;
    for (int i = 0; i < 260; i++) push(-300000, 250000, "R9 fade out");
    chk("R9 gain at zero", g, 0);
    chk("R9 silent", longint'(out_left), 0);
    @(negedge clk); @(negedge clk);
    chk("R11 drained", out_valid, 0);
  endtask

  initial begin
    #50000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_unmute();
    t_stereo();
    t_mono();
    t_atten();
    t_overflow();
    t_stall();
    t_mute();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule